// File: doc/BRIEF.md
# Fracturable Six-Input Logic Cell

This block is a configurable logic cell built around one 64-bit truth-table mask held as static configuration. Eight data inputs, grouped as two bits each on the `a`, `b`, `c` and `d` ports, are steered into the mask by a 3-bit mode code. Depending on that code, the mask serves as one 6-input function, as two smaller functions that may share some inputs, as one function evaluated twice over two input sets, or as a partial 7-input function built from two 5-input halves.

The cell has two combinational outputs. Each also feeds its own flip-flop, which gives two registered copies. The mode and the mask are meant to stay static while the cell is in use. Below, the low half of the mask is bits 31..0 and the high half is bits 63..32. The bit of each input pair is written as x1 = `x_i[0]` and x2 = `x_i[1]`. In every formula, `{...}` is a mask bit index with its most significant bit first.

Top module: `frac_lut_cell`

## Requirements
- R1: Mode 0 (single 6-input): `comb_o[0]` = mask[{d2,c1,b2,b1,a2,a1}], so d2 picks the mask half. `comb_o[1]` is 0.
- R2: Mode 1 (two 5-input functions sharing a1 and a2): `comb_o[0]` = mask[{0,d1,c1,b1,a2,a1}] and `comb_o[1]` = mask[{1,d2,c2,b2,a2,a1}].
- R3: Mode 2 (two independent 4-input functions): `comb_o[0]` = mask[{0,0,d1,c1,b1,a1}] and `comb_o[1]` = mask[{1,0,d2,c2,b2,a2}]. Each function reads only its own four inputs.
- R4: Mode 3 (one mask shared by two 6-input functions): `comb_o[0]` = mask[{d1,c1,b2,b1,a2,a1}] and `comb_o[1]` = mask[{d2,c2,b2,b1,a2,a1}]. The two outputs are equal whenever c1 = c2 and d1 = d2.
- R5: Mode 4 (partial 7-input): when c1 = 0, `comb_o[0]` = mask[{0,d1,b2,b1,a2,a1}]. When c1 = 1, `comb_o[0]` = mask[{1,d1,c2,b2,a2,a1}]. d2 has no effect and `comb_o[1]` is 0.
- R6: In modes 1 and 2, `comb_o[0]` depends only on the low half of the mask and `comb_o[1]` only on the high half.
- R7: Mode codes 5, 6 and 7 drive both combinational outputs to 0.
- R8: On each rising clock edge outside reset, `reg_o[i]` takes the value `comb_o[i]` had at that edge.
- R9: While `rst_ni` is low, both registered outputs are 0. The reset acts at once, without waiting for a clock edge.
- R10: In mode 3, a mask with bit i = bit i[5:4] of i[3:0] turns the cell into two 4:1 multiplexers. Both share the data {b2,b1,a2,a1}: output 0 is selected by {d1,c1} and output 1 by {d2,c2}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output flip-flops |
| rst_ni | input | 1 | Active-low asynchronous reset of the flip-flops |
| mode_i | input | 3 | Static mode code (0 to 4 defined) |
| mask_i | input | 64 | Static truth-table mask |
| a_i | input | 2 | Data inputs a1 (bit 0) and a2 (bit 1) |
| b_i | input | 2 | Data inputs b1 (bit 0) and b2 (bit 1) |
| c_i | input | 2 | Data inputs c1 (bit 0) and c2 (bit 1) |
| d_i | input | 2 | Data inputs d1 (bit 0) and d2 (bit 1) |
| comb_o | output | 2 | Combinational function outputs |
| reg_o | output | 2 | Registered copies of comb_o |

## Verification
The assertions check several properties on every cycle:
- undefined mode codes give zero outputs, and the spare output is idle in modes 0 and 4;
- in the shared-mask mode, the two outputs agree whenever their select inputs agree;
- d2 never disturbs the partial 7-input output;
- in the split modes, output 0 holds while its half of the mask and its inputs hold;
- each flip-flop follows its combinational output and is cleared under reset.

Only the bench's sweeps can show that every mask index is mapped exactly as stated in each mode. The same holds for the effect of flipping one mask half in the split modes, and for the multiplexer use of the shared mask.

// File: rtl/frac_lut_pkg.sv
package frac_lut_pkg;
  localparam int HALF_K  = 5;
  localparam int HALF_W  = 1 << HALF_K;
  localparam int MASK_W  = 2 * HALF_W;
  localparam int NUM_OUT = 2;
  localparam int MODE_W  = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_LUT6    = 3'd0,
    MODE_DUAL5   = 3'd1,
    MODE_DUAL4   = 3'd2,
    MODE_SHARED6 = 3'd3,
    MODE_SPLIT7  = 3'd4
  } cell_mode_e;
endpackage

// File: rtl/frac_lut_tree.sv
module frac_lut_tree #(
  parameter int K = 5
) (
  input  logic [(1<<K)-1:0] tbl_i,
  input  logic [K-1:0]      idx_i,
  output logic              bit_o
);
  localparam int N = 1 << K;

  // heap-ordered 2:1 mux tree: node 1 is the root, leaves at N..2N-1
  logic [2*N-1:1] node;

  assign node[2*N-1:N] = tbl_i;

  for (genvar dep = 0; dep < K; dep++) begin : g_lvl
    for (genvar q = 0; q < (1 << dep); q++) begin : g_mux
      localparam int I = (1 << dep) + q;
      assign node[I] = idx_i[K-1-dep] ? node[2*I+1] : node[2*I];
    end
  end

  assign bit_o = node[1];
endmodule

// File: rtl/frac_lut_steer.sv
module frac_lut_steer
  import frac_lut_pkg::*;
(
  input  logic [MODE_W-1:0]               mode_i,
  input  logic [1:0]                      a_i,
  input  logic [1:0]                      b_i,
  input  logic [1:0]                      c_i,
  input  logic [1:0]                      d_i,
  output logic [NUM_OUT-1:0][HALF_K-1:0]  idx_lo_o,
  output logic [NUM_OUT-1:0][HALF_K-1:0]  idx_hi_o,
  output logic [NUM_OUT-1:0]              sel_hi_o,
  output logic [NUM_OUT-1:0]              en_o
);
  logic a1, a2, b1, b2, c1, c2, d1, d2;
  assign {a2, a1} = a_i;
  assign {b2, b1} = b_i;
  assign {c2, c1} = c_i;
  assign {d2, d1} = d_i;

  always_comb begin
    idx_lo_o = '0;
    idx_hi_o = '0;
    sel_hi_o = '0;
    en_o     = '0;
    case (cell_mode_e'(mode_i))
      MODE_LUT6: begin
        idx_lo_o[0] = {c1, b2, b1, a2, a1};
        idx_hi_o[0] = {c1, b2, b1, a2, a1};
        sel_hi_o[0] = d2;
        en_o        = 2'b01;
      end
      MODE_DUAL5: begin
        idx_lo_o[0] = {d1, c1, b1, a2, a1};
        idx_hi_o[1] = {d2, c2, b2, a2, a1};
        sel_hi_o    = 2'b10;
        en_o        = 2'b11;
      end
      MODE_DUAL4: begin
        idx_lo_o[0] = {1'b0, d1, c1, b1, a1};
        idx_hi_o[1] = {1'b0, d2, c2, b2, a2};
        sel_hi_o    = 2'b10;
        en_o        = 2'b11;
      end
      MODE_SHARED6: begin
        idx_lo_o[0] = {c1, b2, b1, a2, a1};
        idx_hi_o[0] = {c1, b2, b1, a2, a1};
        idx_lo_o[1] = {c2, b2, b1, a2, a1};
        idx_hi_o[1] = {c2, b2, b1, a2, a1};
        sel_hi_o    = {d2, d1};
        en_o        = 2'b11;
      end
      MODE_SPLIT7: begin
        idx_lo_o[0] = {d1, b2, b1, a2, a1};
        idx_hi_o[0] = {d1, c2, b2, a2, a1};
        sel_hi_o[0] = c1;
        en_o        = 2'b01;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/frac_lut_ff.sv
module frac_lut_ff #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end

  AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (q_o == $past(d_i))); // R8

  always_ff @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_CLEAR: assert (q_o == '0); // R9
  end
endmodule

// File: rtl/frac_lut_cell.sv
module frac_lut_cell
  import frac_lut_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [MASK_W-1:0]   mask_i,
  input  logic [1:0]          a_i,
  input  logic [1:0]          b_i,
  input  logic [1:0]          c_i,
  input  logic [1:0]          d_i,
  output logic [NUM_OUT-1:0]  comb_o,
  output logic [NUM_OUT-1:0]  reg_o
);
  logic [NUM_OUT-1:0][HALF_K-1:0] idx_lo, idx_hi;
  logic [NUM_OUT-1:0]             sel_hi, en;

  frac_lut_steer u_steer (
    .mode_i   (mode_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .c_i      (c_i),
    .d_i      (d_i),
    .idx_lo_o (idx_lo),
    .idx_hi_o (idx_hi),
    .sel_hi_o (sel_hi),
    .en_o     (en)
  );

  for (genvar p = 0; p < NUM_OUT; p++) begin : g_out
    logic lo_bit, hi_bit;

    frac_lut_tree #(.K(HALF_K)) u_lo (
      .tbl_i (mask_i[HALF_W-1:0]),
      .idx_i (idx_lo[p]),
      .bit_o (lo_bit)
    );

    frac_lut_tree #(.K(HALF_K)) u_hi (
      .tbl_i (mask_i[MASK_W-1:HALF_W]),
      .idx_i (idx_hi[p]),
      .bit_o (hi_bit)
    );

    assign comb_o[p] = en[p] & (sel_hi[p] ? hi_bit : lo_bit);
  end

  frac_lut_ff #(.W(NUM_OUT)) u_ff (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (comb_o),
    .q_o    (reg_o)
  );

  AST_UNDEF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i > 3'd4) |-> (comb_o == '0)); // R7

  AST_SPARE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd0 || mode_i == 3'd4) |-> (comb_o[1] == 1'b0)); // R1

  AST_SHARED_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd3 && c_i[0] == c_i[1] && d_i[0] == d_i[1])
      |-> (comb_o[0] == comb_o[1])); // R4

  AST_SPLIT7_D2_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd4 && $stable(mode_i) && $stable(mask_i) && $stable(a_i)
     && $stable(b_i) && $stable(c_i) && $stable(d_i[0]))
      |-> $stable(comb_o)); // R5

  AST_SPLIT_ISOLATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 3'd1 || mode_i == 3'd2) && $stable(mode_i)
     && $stable(mask_i[HALF_W-1:0]) && $stable(a_i) && $stable(b_i[0])
     && $stable(c_i[0]) && $stable(d_i[0]))
      |-> $stable(comb_o[0])); // R6
endmodule

// File: tb/tb_frac_lut_cell.sv
module tb_frac_lut_cell;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [2:0]  mode_i;
  logic [63:0] mask_i;
  logic [1:0]  a_i, b_i, c_i, d_i;
  logic [1:0]  comb_o, reg_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  frac_lut_cell dut (
    .clk_i (clk_i), .rst_ni (rst_ni), .mode_i (mode_i), .mask_i (mask_i),
    .a_i (a_i), .b_i (b_i), .c_i (c_i), .d_i (d_i),
    .comb_o (comb_o), .reg_o (reg_o)
  );

  function automatic logic [1:0] model(int md, logic [63:0] m, logic [7:0] v);
    logic a1, a2, b1, b2, c1, c2, d1, d2;
    logic [1:0] r;
    {d2, d1, c2, c1, b2, b1, a2, a1} = v;
    r = 2'b00;
    case (md)
      0: r[0] = m[{d2, c1, b2, b1, a2, a1}];
      1: begin
        r[0] = m[{1'b0, d1, c1, b1, a2, a1}];
        r[1] = m[{1'b1, d2, c2, b2, a2, a1}];
      end
      2: begin
        r[0] = m[{2'b00, d1, c1, b1, a1}];
        r[1] = m[{2'b10, d2, c2, b2, a2}];
      end
      3: begin
        r[0] = m[{d1, c1, b2, b1, a2, a1}];
        r[1] = m[{d2, c2, b2, b1, a2, a1}];
      end
      4: r[0] = c1 ? m[{1'b1, d1, c2, b2, a2, a1}] : m[{1'b0, d1, b2, b1, a2, a1}];
      default: r = 2'b00;
    endcase
    return r;
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(int md, logic [63:0] m, logic [7:0] v);
    mode_i = 3'(md);
    mask_i = m;
    {d_i[1], d_i[0], c_i[1], c_i[0], b_i[1], b_i[0], a_i[1], a_i[0]} = v;
  endtask

  function automatic string req_of(int md);
    case (md)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic sweep(int md, logic [63:0] m);
    for (int v = 0; v < 256; v++) begin
      logic [1:0] exp;
      @(negedge clk_i);
      drive(md, m, 8'(v));
      #1;
      exp = model(md, m, 8'(v));
      check(req_of(md), comb_o, exp);
      @(posedge clk_i);
      #1;
      check("R8", reg_o, exp);
    end
  endtask

  function automatic logic [63:0] pat(int s);
    logic [31:0] hi, lo;
    hi = 32'h9E3779B9 * 32'(s + 1) ^ 32'h5A5A0F0F;
    lo = 32'h7F4A7C15 * 32'(s + 3) ^ 32'hC3C33C3C;
    return {hi, lo};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [63:0] mux_mask;
    rst_ni = 1'b0;
    drive(0, {64{1'b1}}, 8'h00);
    repeat (3) @(posedge clk_i);
    #1;
    check("R9", reg_o, 2'b00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1..R5, R7, R8: every mode code against several masks
    for (int md = 0; md < 8; md++) begin
      for (int s = 0; s < 3; s++) sweep(md, pat(s));
    end
    sweep(3, {64{1'b1}});

    // R6: flipping the other half leaves each split output unchanged
    for (int md = 1; md < 3; md++) begin
      for (int v = 0; v < 256; v++) begin
        logic [1:0] base, flip_hi, flip_lo;
        @(negedge clk_i);
        drive(md, pat(5), 8'(v));
        #1; base = comb_o;
        mask_i = pat(5) ^ {32'hFFFFFFFF, 32'h0};
        #1; flip_hi = comb_o;
        mask_i = pat(5) ^ {32'h0, 32'hFFFFFFFF};
        #1; flip_lo = comb_o;
        check("R6", {flip_hi[1], flip_hi[0]}, {~base[1], base[0]});
        check("R6", {flip_lo[1], flip_lo[0]}, {base[1], ~base[0]});
      end
    end

    // R10: shared mask as two 4:1 multiplexers over common data
    for (int i = 0; i < 64; i++) begin
      logic [5:0] ii;
      logic [3:0] dv;
      ii = 6'(i);
      dv = ii[3:0];
      mux_mask[i] = dv[ii[5:4]];
    end
    for (int v = 0; v < 256; v++) begin
      logic [7:0] vv;
      logic [3:0] data;
      logic [1:0] s0, s1;
      vv = 8'(v);
      data = {vv[3], vv[2], vv[1], vv[0]};
      s0 = {vv[6], vv[4]};
      s1 = {vv[7], vv[5]};
      @(negedge clk_i);
      drive(3, mux_mask, vv);
      #1;
      check("R10", comb_o, {data[s1], data[s0]});
    end

    // R9: asynchronous reset clears between edges
    @(negedge clk_i);
    drive(0, {64{1'b1}}, 8'h00);
    @(posedge clk_i);
    #1;
    check("R8", reg_o, 2'b01);
    #2;
    rst_ni = 1'b0;
    #1;
    check("R9", reg_o, 2'b00);
    @(posedge clk_i);
    #1;
    check("R9", reg_o, 2'b00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    check("R8", reg_o, 2'b01);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule